// File: doc/BRIEF.md
# ADC input channel scan selector

This block decides, sample by sample, which analog input a converter's sample-and-hold should see. It produces a positive-input select code and a one-bit negative-input select. Two channel settings, A and B, are held at the inputs, each with a positive select field and a negative select bit. The block can stay on setting A, alternate between A and B on successive samples, or walk setting A's positive input through the inputs enabled in a 16-bit scan mask. Alternating and scanning can be used together.

Each `sampleTaken` pulse moves the sequence one step forward. An `intEvent` pulse, raised when the converter signals the end of a group of samples, returns the sequence to its start. The block also keeps a register that says which of the 16 pins are digital. It uses that register to flag a sample that would read a digital pin, and reports the inverse as the set of analog pins.

Top module: `adc_scan_sel`

## Requirements
- R1: After reset the pin-configuration register marks every pin analog (`analogPins` = 0xFFFF), `seqRestart` is 0, and the sequence sits on setting A at scan position 0.
- R2: With `altEn`=0 and `scanEn`=0, `posSel` equals `chanPosA` and `negSel` equals `chanNegA` for every sample.
- R3: `negSel` carries the negative bit of the setting in use: 1 selects input 1 and 0 selects the negative voltage reference.
- R4: With `altEn`=1 the samples use setting A, B, A, B and so on. Each sequence starts with A, both after reset and after a restart.
- R5: With `scanEn`=1 and a nonzero `scanMask`, each sample that uses setting A gives a `posSel` equal to the next set mask bit at or above the scan position, in ascending order. After the highest set bit the walk wraps to the lowest.
- R6: With `scanEn`=1 and `scanMask`=0, setting A's `chanPosA` is used unchanged.
- R7: When alternating and scanning are both on, samples that use setting B do not move the scan position. The sequence runs A(first bit), B, A(second bit), B, and so on.
- R8: An `intEvent` pulse resets the scan position to 0 and the phase to setting A. In the next cycle `posSel` shows setting A at the lowest enabled input, and `seqRestart` is high for exactly that one cycle.
- R9: If `intEvent` and `sampleTaken` arrive in the same cycle, the restart wins and the sample does not advance the sequence.
- R10: A `pinCfgLoad` pulse stores `pinCfgIn` into the pin register, where bit i = 1 makes pin i digital. `analogPins` shows the bitwise inverse from the next cycle on.
- R11: `sampleInvalid` is 1 when the pin selected by `posSel` is digital, or when `negSel`=1 and pin 1 is digital.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanPosA | input | 4 | Setting A positive-input select |
| chanNegA | input | 1 | Setting A negative select (1 = input 1, 0 = negative reference) |
| chanPosB | input | 4 | Setting B positive-input select |
| chanNegB | input | 1 | Setting B negative select |
| altEn | input | 1 | Alternate between settings A and B |
| scanEn | input | 1 | Scan setting A's positive input through the mask |
| scanMask | input | 16 | Inputs enabled for scanning |
| sampleTaken | input | 1 | Sample taken; advance the sequence |
| intEvent | input | 1 | End-of-group event; restart the sequence |
| pinCfgLoad | input | 1 | Load strobe for the pin register |
| pinCfgIn | input | 16 | New pin configuration (1 = digital) |
| posSel | output | 4 | Positive-input select for the current sample |
| negSel | output | 1 | Negative-input select for the current sample |
| seqRestart | output | 1 | One-cycle pulse after a restart |
| sampleInvalid | output | 1 | Current selection reads a digital pin |
| analogPins | output | 16 | Pins currently configured as analog |

## Verification
The restart and the sequence advance can fall on the same clock edge. The bench first moves the sequence partway through a scan with alternating on, then raises `intEvent` and `sampleTaken` together. The collision is judged correct when the next cycle shows setting A at the lowest enabled input and the sample after that selects setting B. That second check shows the colliding sample advanced neither the phase nor the scan position.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  // Strobes the control half sends to the datapath each cycle.
  typedef struct packed {
    logic restart;     // return to setting A, scan position 0
    logic scanStep;    // move scan position past the current input
    logic phaseFlip;   // toggle A/B phase
    logic phaseClear;  // force phase to A
  } seqStrobes_t;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import adc_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleTaken,
  input  logic        intEvent,
  input  logic        altEn,
  input  logic        scanEn,
  input  logic        altPhase,
  output seqStrobes_t strobes,
  output logic        seqRestart
);
  logic stepOk;
  logic usedB;

  // A restart swallows a sample that arrives in the same cycle.
  assign stepOk = sampleTaken && !intEvent;
  assign usedB  = altEn && altPhase;

  always_comb begin
    strobes            = '0;
    strobes.restart    = intEvent;
    strobes.scanStep   = stepOk && scanEn && !usedB;
    strobes.phaseFlip  = stepOk && altEn;
    strobes.phaseClear = stepOk && !altEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) seqRestart <= 1'b0;
    else       seqRestart <= intEvent;
  end

  // R8: a restart pulse is seen exactly one cycle after the event
  a_r8_restart_pulse: assert property (@(posedge clk) disable iff (!rstN)
    intEvent |=> seqRestart);
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    !intEvent |=> !seqRestart);
  // R9: a colliding sample never moves phase or scan
  a_r9_restart_wins: assert property (@(posedge clk) disable iff (!rstN)
    (intEvent && sampleTaken) |-> !(strobes.scanStep || strobes.phaseFlip));
endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int SEL_W = $clog2(NUM_CH)
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [SEL_W-1:0]  chanPosA,
  input  logic              chanNegA,
  input  logic [SEL_W-1:0]  chanPosB,
  input  logic              chanNegB,
  input  logic              altEn,
  input  logic              scanEn,
  input  logic [NUM_CH-1:0] scanMask,
  input  logic              pinCfgLoad,
  input  logic [NUM_CH-1:0] pinCfgIn,
  output logic              altPhase,
  output logic [SEL_W-1:0]  posSel,
  output logic              negSel,
  output logic              sampleInvalid,
  output logic [NUM_CH-1:0] analogPins
);
  logic [SEL_W-1:0]  scanPos;
  logic [SEL_W-1:0]  curIdx;
  logic [SEL_W-1:0]  stepIdx;
  logic [NUM_CH-1:0] digitalCfg;
  logic              found;
  logic              scanOn;
  logic              useB;

  // Cyclic search: first enabled input at or above the scan position.
  always_comb begin
    found  = 1'b0;
    curIdx = scanPos;
    for (int k = 0; k < NUM_CH; k++) begin
      if (!found && scanMask[(int'(scanPos) + k) % NUM_CH]) begin
        found  = 1'b1;
        curIdx = SEL_W'((int'(scanPos) + k) % NUM_CH);
      end
    end
  end

  assign stepIdx = (int'(curIdx) == NUM_CH - 1) ? '0 : curIdx + 1'b1;
  assign scanOn  = scanEn && (|scanMask);
  assign useB    = altEn && altPhase;

  always_comb begin
    if (useB) begin
      posSel = chanPosB;
      negSel = chanNegB;
    end else begin
      posSel = scanOn ? curIdx : chanPosA;
      negSel = chanNegA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanPos  <= '0;
      altPhase <= 1'b0;
    end else if (strobes.restart) begin
      scanPos  <= '0;
      altPhase <= 1'b0;
    end else begin
      if (strobes.scanStep)   scanPos  <= stepIdx;
      if (strobes.phaseFlip)  altPhase <= ~altPhase;
      if (strobes.phaseClear) altPhase <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           digitalCfg <= '0;
    else if (pinCfgLoad) digitalCfg <= pinCfgIn;
  end

  assign analogPins    = ~digitalCfg;
  assign sampleInvalid = digitalCfg[posSel] | (negSel & digitalCfg[1]);

  // R5: a scanned A sample always lands on an enabled input
  a_r5_scan_hits_mask: assert property (@(posedge clk) disable iff (!rstN)
    (scanOn && !useB) |-> scanMask[posSel]);
  // R8: restart returns to the sequence origin
  a_r8_restart_home: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (scanPos == '0 && !altPhase));
  // R4: a flip strobe changes the phase
  a_r4_alt_flip: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.phaseFlip && !strobes.restart) |=> altPhase != $past(altPhase));
  // R7: a B sample leaves the scan position alone
  a_r7_b_holds_scan: assert property (@(posedge clk) disable iff (!rstN)
    (useB && !strobes.restart) |=> $stable(scanPos));
  // R10: loaded configuration appears inverted on the analog set
  a_r10_pin_load: assert property (@(posedge clk) disable iff (!rstN)
    pinCfgLoad |=> analogPins == ~$past(pinCfgIn));
endmodule

// File: rtl/adc_scan_sel.sv
module adc_scan_sel
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int SEL_W = $clog2(NUM_CH)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  chanPosA,
  input  logic              chanNegA,
  input  logic [SEL_W-1:0]  chanPosB,
  input  logic              chanNegB,
  input  logic              altEn,
  input  logic              scanEn,
  input  logic [NUM_CH-1:0] scanMask,
  input  logic              sampleTaken,
  input  logic              intEvent,
  input  logic              pinCfgLoad,
  input  logic [NUM_CH-1:0] pinCfgIn,
  output logic [SEL_W-1:0]  posSel,
  output logic              negSel,
  output logic              seqRestart,
  output logic              sampleInvalid,
  output logic [NUM_CH-1:0] analogPins
);
  seqStrobes_t strobes;
  logic        altPhase;

  scan_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTaken(sampleTaken), .intEvent(intEvent),
    .altEn(altEn), .scanEn(scanEn), .altPhase(altPhase),
    .strobes(strobes), .seqRestart(seqRestart)
  );

  scan_seq_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .chanPosA(chanPosA), .chanNegA(chanNegA),
    .chanPosB(chanPosB), .chanNegB(chanNegB),
    .altEn(altEn), .scanEn(scanEn), .scanMask(scanMask),
    .pinCfgLoad(pinCfgLoad), .pinCfgIn(pinCfgIn),
    .altPhase(altPhase), .posSel(posSel), .negSel(negSel),
    .sampleInvalid(sampleInvalid), .analogPins(analogPins)
  );
endmodule

// File: tb/sim_adc_scan_sel.sv
module sim_adc_scan_sel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  chanPosA = 4'd5, chanPosB = 4'd3;
  logic        chanNegA = 1'b0, chanNegB = 1'b0;
  logic        altEn = 1'b0, scanEn = 1'b0;
  logic [15:0] scanMask = '0;
  logic        sampleTaken = 1'b0, intEvent = 1'b0;
  logic        pinCfgLoad = 1'b0;
  logic [15:0] pinCfgIn = '0;
  logic [3:0]  posSel;
  logic        negSel, seqRestart, sampleInvalid;
  logic [15:0] analogPins;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_scan_sel u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseSample();
    @(negedge clk); sampleTaken = 1'b1;
    @(negedge clk); sampleTaken = 1'b0;
  endtask

  task automatic pulseInt();
    @(negedge clk); intEvent = 1'b1;
    @(negedge clk); intEvent = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 analogPins", analogPins, 32'hFFFF);
    check("R1 seqRestart", seqRestart, 0);
    check("R1 posSel", posSel, 5);
    check("R1 sampleInvalid", sampleInvalid, 0);
  endtask

  task automatic t_fixed();
    chanPosA = 4'd9; chanNegA = 1'b1; chanPosB = 4'd3; chanNegB = 1'b0;
    for (int i = 0; i < 3; i++) begin
      pulseSample();
      check("R2 fixed posSel", posSel, 9);
      check("R3 fixed negSel", negSel, 1);
    end
  endtask

  task automatic t_alt();
    altEn = 1'b1;
    pulseInt();
    check("R4 alt first A", posSel, 9);
    pulseSample();
    check("R4 alt B pos", posSel, 3);
    check("R3 alt B neg reference", negSel, 0);
    pulseSample();
    check("R4 alt back to A", posSel, 9);
    check("R3 alt A neg input1", negSel, 1);
    altEn = 1'b0;
  endtask

  task automatic t_scan();
    logic [3:0] expSeq [6] = '{4'd1, 4'd4, 4'd6, 4'd11, 4'd1, 4'd4};
    scanEn = 1'b1; scanMask = 16'h0852;
    pulseInt();
    for (int i = 0; i < 6; i++) begin
      check("R5 scan order", posSel, expSeq[i]);
      pulseSample();
    end
  endtask

  task automatic t_zeroMask();
    scanMask = 16'h0000;
    pulseSample();
    check("R6 zero mask uses A", posSel, 9);
    scanEn = 1'b0;
  endtask

  task automatic t_altScan();
    logic [3:0] expSeq [5] = '{4'd1, 4'd3, 4'd4, 4'd3, 4'd1};
    scanEn = 1'b1; altEn = 1'b1; scanMask = 16'h0012;
    pulseInt();
    for (int i = 0; i < 5; i++) begin
      check("R7 alt+scan order", posSel, expSeq[i]);
      pulseSample();
    end
    altEn = 1'b0;
  endtask

  task automatic t_restart();
    scanMask = 16'h0852;
    pulseInt();
    pulseSample(); pulseSample();
    check("R5 before restart", posSel, 6);
    pulseInt();
    check("R8 restart lowest", posSel, 1);
    check("R8 seqRestart high", seqRestart, 1);
    @(negedge clk);
    check("R8 seqRestart single", seqRestart, 0);
  endtask

  task automatic t_collide();
    altEn = 1'b1;
    pulseInt();
    pulseSample(); pulseSample();
    check("R9 pre-collision A second bit", posSel, 4);
    @(negedge clk); intEvent = 1'b1; sampleTaken = 1'b1;
    @(negedge clk); intEvent = 1'b0; sampleTaken = 1'b0;
    check("R9 collision restart wins", posSel, 1);
    pulseSample();
    check("R9 next is B", posSel, 3);
    altEn = 1'b0;
  endtask

  task automatic t_pins();
    @(negedge clk); pinCfgLoad = 1'b1; pinCfgIn = 16'h0010;
    @(negedge clk); pinCfgLoad = 1'b0;
    check("R10 analogPins", analogPins, 32'hFFEF);
    scanMask = 16'h0012; chanNegA = 1'b1;
    pulseInt();
    check("R11 analog pin valid", sampleInvalid, 0);
    pulseSample();
    check("R11 digital pos pin", posSel, 4);
    check("R11 digital pos invalid", sampleInvalid, 1);
    @(negedge clk); pinCfgLoad = 1'b1; pinCfgIn = 16'h0002;
    @(negedge clk); pinCfgLoad = 1'b0; chanNegA = 1'b0;
    check("R10 analogPins reload", analogPins, 32'hFFFD);
    #1;
    check("R11 neg ref ok", sampleInvalid, 0);
    chanNegA = 1'b1; #1;
    check("R11 neg input1 digital", sampleInvalid, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_alt();
    t_scan();
    t_zeroMask();
    t_altScan();
    t_restart();
    t_collide();
    t_pins();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog run did not finish");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule